// File: doc/BRIEF.md
# Sync-Triggered Video Field Capture

This block takes in a 16-bit parallel video stream, with one 8-bit luma lane and one 8-bit chroma lane, on the pixel clock. Three plain inputs come with it: a horizontal sync, a vertical sync and a field indicator. The source has no data-enable signal. The block therefore decides which clocks carry picture data from three things only: the sync edges, a programmed window size (pixels per line, lines per field) and programmed start offsets. Once a vertical sync edge arms a field, every horizontal sync edge starts a new line. The block forwards the pixels that fall inside the window as a stream. Each beat is tagged with start-of-field, end-of-line and the parity of the field.

The captured stream leaves through a valid/ready port. The video source cannot be stalled, so back-pressure is handled without stalling it. A beat that has been offered stays unchanged until the consumer takes it. Any further pixel that is captured while that beat waits is dropped, and a one-cycle drop pulse reports the loss. The sink must keep ready high to receive every pixel.

Two faults on the source side are flagged or tolerated. A line that is shorter than the programmed window is cut at the next horizontal sync edge, and an overrun pulse is raised. Sync edges that fall outside an armed field are ignored. If a vertical and a horizontal edge are detected in the same cycle, the horizontal edge is discarded.

Top module: `vcap_top`

## Requirements
- R1: A vertical sync edge is accepted only when one idle sample is followed by two consecutive active samples. `cfg_vs_pol` = 0 makes the high level active, and `cfg_vs_pol` = 1 makes the low level active. A pulse that is active for one sample only is ignored.
- R2: Horizontal sync edges are detected by the same two-sample rule, with `cfg_hs_pol` selecting the level in the same way. The first active horizontal sync sample carries pixel index 0 of the line, and a one-sample horizontal pulse neither starts a line nor advances the line count.
- R3: On each captured line the block outputs pixel indices `hoff` through `hoff+width-1` in arrival order. `o_data` carries the luma lane in bits 15:8 and the chroma lane in bits 7:0.
- R4: The first horizontal sync edge after a vertical sync edge is line index 0. Lines `voff` through `voff+height-1` are captured.
- R5: Horizontal sync edges that arrive before any vertical sync edge produce no output. So do the edges from line index `voff+height` onward, until the next vertical sync edge.
- R6: `o_odd` on every beat of a field equals the level of `i_field` at the first active vertical sync sample of that field.
- R7: `o_sof` is 1 on the first beat of a field only. `o_eol` is 1 only on the beat carrying pixel index `hoff+width-1`.
- R8: If a horizontal sync edge arrives before a captured line has delivered its last pixel, the rest of that line is discarded, no `o_eol` is given, and `o_ovr` pulses for one cycle.
- R9: Width, height and both offsets are sampled at each vertical sync edge and held for the whole field. Changes made mid-field take effect at the next field.
- R10: While `o_valid` is 1 and `i_out_ready` is 0, `o_valid` and the beat stay unchanged. A pixel captured in that state is discarded, and `o_drop` pulses for one cycle.
- R11: After reset `o_valid`, `o_ovr` and `o_drop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_luma | input | 8 | Luma lane |
| i_chroma | input | 8 | Chroma lane |
| i_hsync | input | 1 | Horizontal sync level |
| i_vsync | input | 1 | Vertical sync level |
| i_field | input | 1 | Field indicator level |
| cfg_width | input | 12 | Pixels captured per line |
| cfg_height | input | 12 | Lines captured per field |
| cfg_hoff | input | 12 | Pixel index of the first captured pixel |
| cfg_voff | input | 12 | Line index of the first captured line |
| cfg_hs_pol | input | 1 | Horizontal sync active level (0 high, 1 low) |
| cfg_vs_pol | input | 1 | Vertical sync active level (0 high, 1 low) |
| i_out_ready | input | 1 | Consumer ready |
| o_valid | output | 1 | Beat valid |
| o_data | output | 16 | Captured pixel, luma in bits 15:8 |
| o_sof | output | 1 | First beat of the field |
| o_eol | output | 1 | Last beat of the line |
| o_odd | output | 1 | Field parity tag |
| o_ovr | output | 1 | Short-line pulse |
| o_drop | output | 1 | Pixel lost to back-pressure pulse |

## Verification
The assertions check every cycle for the following: sync edges never fire in back-to-back cycles; the window settings stay frozen between vertical edges; nothing is captured once a field is disarmed; no capture follows an end-of-line without a new horizontal edge; an overrun pulse always follows a horizontal edge; and the output beat holds steady under back-pressure. Other behaviour only the directed scenarios can show. These are the exact pixel indices and lines chosen by the offsets, the parity tag, the rejection of one-sample glitches, the point where a mid-field geometry change takes effect, and the number of overrun and drop pulses.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int LANE_W = 8;
  localparam int PIX_W  = 2 * LANE_W;

  typedef struct packed {
    logic [PIX_W-1:0] data;
    logic             sof;
    logic             eol;
    logic             odd;
  } vcap_beat_t;
endpackage

// File: rtl/vcap_sync_edge.sv
// Filtered sync edge detector: one idle sample followed by HOLD active samples.
module vcap_sync_edge #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i_lvl,
  input  logic i_pol,
  output logic o_edge
);
  localparam int DEPTH = HOLD + 1;

  logic [DEPTH-1:0] smp;
  logic [DEPTH-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= '0;
    else        smp <= {smp[DEPTH-2:0], i_lvl};
  end

  always_comb begin
    act    = smp ^ {DEPTH{i_pol}};
    o_edge = (&act[HOLD-1:0]) & ~act[HOLD];
  end

  // R1 / R2: an accepted edge needs a fresh idle sample, so never two in a row
  p_edge_isolated_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    o_edge |=> !o_edge);
endmodule

// File: rtl/vcap_geom_shadow.sv
// Window geometry held for a whole field, reloaded on vertical sync edges.
module vcap_geom_shadow #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_load,
  input  logic [CNT_W-1:0] i_width,
  input  logic [CNT_W-1:0] i_height,
  input  logic [CNT_W-1:0] i_hoff,
  input  logic [CNT_W-1:0] i_voff,
  output logic [CNT_W-1:0] o_width,
  output logic [CNT_W-1:0] o_height,
  output logic [CNT_W-1:0] o_hoff,
  output logic [CNT_W-1:0] o_voff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_width  <= '0;
      o_height <= '0;
      o_hoff   <= '0;
      o_voff   <= '0;
    end else if (i_load) begin
      o_width  <= i_width;
      o_height <= i_height;
      o_hoff   <= i_hoff;
      o_voff   <= i_voff;
    end
  end

  p_geom_frozen_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !i_load |=> ($stable(o_width) && $stable(o_height) &&
                 $stable(o_hoff) && $stable(o_voff)));
endmodule

// File: rtl/vcap_window.sv
// Line/pixel counters that pick the captured window out of the raw stream.
module vcap_window
  import vcap_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_hs_edge,
  input  logic             i_vs_edge,
  input  logic [PIX_W-1:0] i_px,
  input  logic             i_fld,
  input  logic [CNT_W-1:0] i_width,
  input  logic [CNT_W-1:0] i_height,
  input  logic [CNT_W-1:0] i_hoff,
  input  logic [CNT_W-1:0] i_voff,
  output logic             o_fire,
  output vcap_beat_t       o_beat,
  output logic             o_ovr
);
  localparam int EW = CNT_W + 1;

  logic [EW-1:0] h_end, v_end, line_idx, col, cur_col, col_inc, line_inc;
  logic          armed, ln_open, sof_pend, odd_q;
  logic          take_hs, line_in, new_open, open_now, last_px;

  always_comb begin
    h_end    = EW'(i_hoff) + EW'(i_width);
    v_end    = EW'(i_voff) + EW'(i_height);
    take_hs  = i_hs_edge && armed && !i_vs_edge;
    line_in  = (line_idx >= EW'(i_voff)) && (line_idx < v_end);
    new_open = take_hs && line_in && (i_width != '0);
    open_now = i_hs_edge ? new_open : ln_open;
    cur_col  = i_hs_edge ? '0 : col;
    o_fire   = open_now && !i_vs_edge &&
               (cur_col >= EW'(i_hoff)) && (cur_col < h_end);
    last_px  = o_fire && (cur_col == h_end - 1'b1);
    col_inc  = (&cur_col)  ? cur_col  : cur_col + 1'b1;
    line_inc = (&line_idx) ? line_idx : line_idx + 1'b1;
    o_beat.data = i_px;
    o_beat.sof  = sof_pend;
    o_beat.eol  = last_px;
    o_beat.odd  = odd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      ln_open  <= 1'b0;
      sof_pend <= 1'b0;
      odd_q    <= 1'b0;
      line_idx <= '0;
      col      <= '0;
      o_ovr    <= 1'b0;
    end else begin
      col   <= col_inc;
      o_ovr <= i_hs_edge && ln_open;
      if (i_vs_edge) begin
        armed    <= 1'b1;
        line_idx <= '0;
        odd_q    <= i_fld;
        sof_pend <= 1'b1;
        ln_open  <= 1'b0;
      end else begin
        ln_open <= open_now && !last_px;
        if (take_hs) begin
          line_idx <= line_inc;
          if (line_idx >= v_end) armed <= 1'b0;
        end
        if (o_fire) sof_pend <= 1'b0;
      end
    end
  end

  p_ovr_after_hs_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    o_ovr |-> $past(i_hs_edge));
  p_eol_closes_line_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (o_fire && o_beat.eol) |=> (!o_fire || i_hs_edge));
  p_sof_single_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (o_fire && o_beat.sof) |=> !(o_fire && o_beat.sof));
  p_idle_when_disarmed_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !ln_open) |-> !o_fire);
endmodule

// File: rtl/vcap_out_reg.sv
// One-beat valid/ready output register; the source cannot stall, so overflow drops.
module vcap_out_reg
  import vcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       i_fire,
  input  vcap_beat_t i_beat,
  input  logic       i_ready,
  output logic       o_valid,
  output vcap_beat_t o_beat,
  output logic       o_drop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_beat  <= '0;
      o_drop  <= 1'b0;
    end else begin
      o_drop <= i_fire && o_valid && !i_ready;
      if (!o_valid || i_ready) begin
        o_valid <= i_fire;
        if (i_fire) o_beat <= i_beat;
      end
    end
  end

  p_hold_under_stall_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !i_ready) |=> (o_valid && $stable(o_beat)));
  p_drop_only_when_held_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    o_drop |-> $past(o_valid && !i_ready));
endmodule

// File: rtl/vcap_top.sv
module vcap_top
  import vcap_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SYNC_HOLD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANE_W-1:0]   i_luma,
  input  logic [LANE_W-1:0]   i_chroma,
  input  logic                i_hsync,
  input  logic                i_vsync,
  input  logic                i_field,
  input  logic [CNT_W-1:0]    cfg_width,
  input  logic [CNT_W-1:0]    cfg_height,
  input  logic [CNT_W-1:0]    cfg_hoff,
  input  logic [CNT_W-1:0]    cfg_voff,
  input  logic                cfg_hs_pol,
  input  logic                cfg_vs_pol,
  input  logic                i_out_ready,
  output logic                o_valid,
  output logic [PIX_W-1:0]    o_data,
  output logic                o_sof,
  output logic                o_eol,
  output logic                o_odd,
  output logic                o_ovr,
  output logic                o_drop
);
  localparam int SLOT_W = PIX_W + 1;

  logic              hs_edge, vs_edge, fire;
  logic [SLOT_W-1:0] dly [SYNC_HOLD];
  logic [CNT_W-1:0]  sh_width, sh_height, sh_hoff, sh_voff;
  vcap_beat_t        cap_beat, out_beat;

  vcap_sync_edge #(.HOLD(SYNC_HOLD)) u_hs_det (
    .clk(clk), .rst_n(rst_n), .i_lvl(i_hsync), .i_pol(cfg_hs_pol), .o_edge(hs_edge));
  vcap_sync_edge #(.HOLD(SYNC_HOLD)) u_vs_det (
    .clk(clk), .rst_n(rst_n), .i_lvl(i_vsync), .i_pol(cfg_vs_pol), .o_edge(vs_edge));

  // Data and field level delayed to line up with the first active sync sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_HOLD; k++) dly[k] <= '0;
    end else begin
      dly[0] <= {i_field, i_luma, i_chroma};
      for (int k = 1; k < SYNC_HOLD; k++) dly[k] <= dly[k-1];
    end
  end

  vcap_geom_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .i_load(vs_edge),
    .i_width(cfg_width), .i_height(cfg_height), .i_hoff(cfg_hoff), .i_voff(cfg_voff),
    .o_width(sh_width), .o_height(sh_height), .o_hoff(sh_hoff), .o_voff(sh_voff));

  vcap_window #(.CNT_W(CNT_W)) u_window (
    .clk(clk), .rst_n(rst_n), .i_hs_edge(hs_edge), .i_vs_edge(vs_edge),
    .i_px(dly[SYNC_HOLD-1][PIX_W-1:0]), .i_fld(dly[SYNC_HOLD-1][PIX_W]),
    .i_width(sh_width), .i_height(sh_height), .i_hoff(sh_hoff), .i_voff(sh_voff),
    .o_fire(fire), .o_beat(cap_beat), .o_ovr(o_ovr));

  vcap_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .i_fire(fire), .i_beat(cap_beat), .i_ready(i_out_ready),
    .o_valid(o_valid), .o_beat(out_beat), .o_drop(o_drop));

  always_comb begin
    o_data = out_beat.data;
    o_sof  = out_beat.sof;
    o_eol  = out_beat.eol;
    o_odd  = out_beat.odd;
  end
endmodule

// File: tb/vcap_top_tb_top.sv
module vcap_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  i_luma = '0, i_chroma = '0;
  logic        i_hsync = 1'b0, i_vsync = 1'b0, i_field = 1'b0;
  logic [11:0] cfg_width = '0, cfg_height = '0, cfg_hoff = '0, cfg_voff = '0;
  logic        cfg_hs_pol = 1'b0, cfg_vs_pol = 1'b0;
  logic        i_out_ready = 1'b1;
  logic        o_valid, o_sof, o_eol, o_odd, o_ovr, o_drop;
  logic [15:0] o_data;

  int n_chk = 0, n_fail = 0;
  int beat_cnt = 0, ovr_cnt = 0, drop_cnt = 0;
  logic [18:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vcap_top dut_i (
    .clk(clk), .rst_n(rst_n), .i_luma(i_luma), .i_chroma(i_chroma),
    .i_hsync(i_hsync), .i_vsync(i_vsync), .i_field(i_field),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_hoff(cfg_hoff), .cfg_voff(cfg_voff),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .i_out_ready(i_out_ready),
    .o_valid(o_valid), .o_data(o_data), .o_sof(o_sof), .o_eol(o_eol), .o_odd(o_odd),
    .o_ovr(o_ovr), .o_drop(o_drop));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor away from the rising edge: every transfer is compared with the model queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (o_ovr)  ovr_cnt++;
      if (o_drop) drop_cnt++;
      if (o_valid && i_out_ready) begin
        logic [18:0] got;
        got = {o_data, o_sof, o_eol, o_odd};
        beat_cnt++;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R3 unexpected beat: actual %h expected none", got);
        end else begin
          logic [18:0] want;
          want = exp_q.pop_front();
          if (got !== want) begin
            n_fail++;
            $display("FAIL R3/R6/R7 beat {data,sof,eol,odd}: actual %h expected %h", got, want);
          end
        end
      end
    end
  end

  task automatic drv(input logic hs, input logic vs, input logic fld,
                     input logic [7:0] y, input logic [7:0] c);
    @(posedge clk); #1;
    i_hsync = hs; i_vsync = vs; i_field = fld; i_luma = y; i_chroma = c;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drv(cfg_hs_pol, cfg_vs_pol, i_field, 8'h00, 8'h00);
  endtask

  // Lines with no vertical sync around them.
  task automatic gen_lines(input int nl, input int per);
    for (int i = 0; i < nl; i++)
      for (int j = 0; j < per; j++)
        drv((j < 2) ? ~cfg_hs_pol : cfg_hs_pol, cfg_vs_pol, i_field, 8'(i), 8'(j));
  endtask

  // One field; the model queue is filled as pixels are driven.
  task automatic gen_field(input int nl, input int per, input bit fld,
                           input int gl, input int midw, input bit only_first);
    int  w, h, ho, vo, len;
    bit  first;
    logic hsv;
    w = int'(cfg_width); h = int'(cfg_height); ho = int'(cfg_hoff); vo = int'(cfg_voff);
    first = 1'b1;
    for (int k = 0; k < 3; k++) drv(cfg_hs_pol, ~cfg_vs_pol, fld, 8'h00, 8'h00);
    for (int k = 0; k < 3; k++) drv(cfg_hs_pol, cfg_vs_pol, fld, 8'h00, 8'h00);
    for (int i = 0; i < nl; i++) begin
      len = (i == nl - 1) ? per + ho + w + 6 : per;
      for (int j = 0; j < len; j++) begin
        hsv = (j < 2 || (i == gl && j == per / 2)) ? ~cfg_hs_pol : cfg_hs_pol;
        drv(hsv, cfg_vs_pol, fld, 8'(i), 8'(j));
        if (i == 0 && j == 3 && midw >= 0) cfg_width = 12'(midw);
        if (i >= vo && i < vo + h && j >= ho && j < ho + w) begin
          if (first || !only_first)
            exp_q.push_back({8'(i), 8'(j), first, (j == ho + w - 1), fld});
          first = 1'b0;
        end
      end
    end
  endtask

  task automatic set_geom(input int w, input int h, input int ho, input int vo,
                          input bit hp, input bit vp);
    cfg_width = 12'(w); cfg_height = 12'(h); cfg_hoff = 12'(ho); cfg_voff = 12'(vo);
    cfg_hs_pol = hp; cfg_vs_pol = vp;
    idle(4);
  endtask

  task automatic finish_scn(input string req, input int b0, input int nb,
                            input int o0, input int no);
    idle(12);
    chk(exp_q.size() == 0, req, "missing beats", exp_q.size(), 0);
    chk(beat_cnt - b0 == nb, req, "beat count", beat_cnt - b0, nb);
    chk(ovr_cnt - o0 == no, "R8", "overrun pulses", ovr_cnt - o0, no);
    exp_q.delete();
  endtask

  task automatic t_reset;
    int b0;
    @(negedge clk);
    chk(o_valid == 1'b0, "R11", "o_valid after reset", o_valid, 0);
    chk(o_ovr == 1'b0,   "R11", "o_ovr after reset", o_ovr, 0);
    chk(o_drop == 1'b0,  "R11", "o_drop after reset", o_drop, 0);
    set_geom(4, 2, 0, 0, 1'b0, 1'b0);
    b0 = beat_cnt;
    gen_lines(3, 10);                      // R5: no vertical sync yet
    idle(8);
    chk(beat_cnt == b0, "R5", "beats before any vsync", beat_cnt - b0, 0);
  endtask

  task automatic t_basic;           // R3 R4 R5 R6 R7
    int b0, o0;
    set_geom(8, 3, 2, 1, 1'b0, 1'b0);
    b0 = beat_cnt; o0 = ovr_cnt;
    gen_field(6, 16, 1'b1, -1, -1, 1'b0);
    finish_scn("R4", b0, 24, o0, 0);
  endtask

  task automatic t_pol;             // R1 R2 with low-active syncs, R6 even field
    int b0, o0;
    set_geom(5, 2, 0, 0, 1'b1, 1'b1);
    b0 = beat_cnt; o0 = ovr_cnt;
    gen_field(4, 10, 1'b0, -1, -1, 1'b0);
    finish_scn("R1", b0, 10, o0, 0);
  endtask

  task automatic t_glitch;
    int b0, o0;
    set_geom(6, 3, 1, 0, 1'b0, 1'b0);
    b0 = beat_cnt;
    drv(1'b0, 1'b1, 1'b0, 8'h00, 8'h00);   // one-sample vertical pulse
    idle(3);
    gen_lines(3, 12);
    idle(8);
    chk(beat_cnt == b0, "R1", "beats after 1-sample vsync", beat_cnt - b0, 0);
    b0 = beat_cnt; o0 = ovr_cnt;
    gen_field(5, 20, 1'b1, 1, -1, 1'b0);   // one-sample hsync inside line 1
    finish_scn("R2", b0, 18, o0, 0);
  endtask

  task automatic t_short;           // R8: lines 8 clocks long, window ends at 12
    int b0, o0;
    set_geom(10, 3, 2, 0, 1'b0, 1'b0);
    b0 = beat_cnt; o0 = ovr_cnt;
    gen_field(5, 8, 1'b0, -1, -1, 1'b0);
    finish_scn("R8", b0, 18, o0, 3);
  endtask

  task automatic t_shadow;          // R9
    int b0, o0;
    set_geom(8, 2, 0, 0, 1'b0, 1'b0);
    b0 = beat_cnt; o0 = ovr_cnt;
    gen_field(3, 12, 1'b1, -1, 3, 1'b0);
    finish_scn("R9", b0, 16, o0, 0);
    b0 = beat_cnt; o0 = ovr_cnt;
    gen_field(3, 12, 1'b0, -1, -1, 1'b0);
    finish_scn("R9", b0, 6, o0, 0);
  endtask

  task automatic t_backpressure;    // R10
    int b0, d0;
    set_geom(5, 1, 0, 0, 1'b0, 1'b0);
    i_out_ready = 1'b0;
    b0 = beat_cnt; d0 = drop_cnt;
    gen_field(2, 10, 1'b1, -1, -1, 1'b1);
    idle(10);
    @(negedge clk);
    chk(o_valid == 1'b1, "R10", "held valid", o_valid, 1);
    chk(o_data == 16'h0000, "R10", "held data", o_data, 0);
    chk(drop_cnt - d0 == 4, "R10", "drop pulses", drop_cnt - d0, 4);
    chk(beat_cnt == b0, "R10", "no transfer while stalled", beat_cnt - b0, 0);
    @(posedge clk); #1;
    i_out_ready = 1'b1;
    idle(4);
    @(negedge clk);
    chk(o_valid == 1'b0, "R10", "valid cleared after accept", o_valid, 0);
    chk(exp_q.size() == 0 && beat_cnt - b0 == 1, "R10", "held beat delivered",
        beat_cnt - b0, 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_pol();
    t_glitch();
    t_short();
    t_shadow();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule